// File: doc/BRIEF.md
# Thread Fork Context Allocator

This block carries out the fork step of a multithreaded core. A parent thread context presents a request holding a start address, the index of a general register and a value for that register. The allocator looks over the thread contexts for a free one that belongs to the same virtual processing element as the parent. It then marks that context as running and activated, and stores the start address as the context's restart address. It also drives one write into the register file so that the chosen register of the new context receives the value. When no context is free, the request still completes, but it raises a thread exception and records a cause code.

The status word of every context is held inside the block. An ordinary write port and a registered read port let surrounding control logic set contexts up and inspect them, including the stored restart address. The scan is a combinational priority search over the current status words. All updates commit on one clock edge, and the acknowledge appears in the cycle that follows. Only one fork is in flight at any time.

Top module: `tc_fork_alloc`

## Requirements
- R1: Only contexts whose index is at most `cfg_last_ctx` are candidates, so the number scanned is `cfg_last_ctx` + 1, capped at NUM_CTX.
- R2: When several contexts qualify, the one with the lowest index is chosen.
- R3: A context qualifies only when all four of these hold: its PE binding (status bits [18:17]) equals the parent's PE binding, its allocatable bit [0] is 1, its halt bit [2] is 0 and its activated bit [1] is 0.
- R4: The chosen context's status is rewritten as follows: activated [1] = 1, run state [6:5] = 0, delay-slot flag [3] = 0, dirty flag [4] = 1. Its PE binding, allocatable bit and halt bit are unchanged.
- R5: The chosen context's mode field [8:7] takes the value of `req_mode`, and its ASID [16:9] is copied from the parent context's ASID.
- R6: The chosen context's restart address becomes `req_start`, and it can be read back on `st_rrestart`.
- R7: A successful fork raises `rf_we` for exactly the acknowledge cycle, together with `rf_ctx` = chosen index, `rf_idx` = `req_reg` and `rf_data` = `req_value`.
- R8: When no context qualifies, the block acknowledges with `ack_ok` = 0 and pulses `exc_valid`. `exc_cause` becomes 1 and keeps that value until reset. No status word changes and no register-file write is issued.
- R9: A request is accepted on a clock edge where `req_valid` is high and `ack` is low. `ack` is a one-cycle pulse in the cycle after acceptance. No request is accepted in the acknowledge cycle.
- R10: A status write through `st_we` takes effect on the next edge. `st_rdata` and `st_rrestart` show the context at `st_ridx` one cycle after it is presented.
- R11: If a status write and a fork hit the same context on the same edge, the fork result is kept. A status write to any other context on that edge is applied. The scan always sees the status as it stood before the edge.
- R12: After reset, all status words are zero, and `ack`, `ack_ok`, `exc_valid`, `exc_cause` and `rf_we` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_last_ctx | input | CTX_W | Highest context index included in the scan |
| req_valid | input | 1 | Fork request present |
| req_parent | input | CTX_W | Index of the requesting parent context |
| req_mode | input | 2 | Parent's global privilege mode |
| req_start | input | ADDR_W | Start address for the child |
| req_reg | input | RIDX_W | Register index to write in the child |
| req_value | input | DATA_W | Value for that register |
| ack | output | 1 | Request completed (one-cycle pulse) |
| ack_ok | output | 1 | A context was allocated |
| ack_ctx | output | CTX_W | Index of the allocated context |
| exc_valid | output | 1 | Thread exception pulse |
| exc_cause | output | 3 | Exception cause code, held until reset |
| rf_we | output | 1 | Register-file write enable |
| rf_ctx | output | CTX_W | Context targeted by the write |
| rf_idx | output | RIDX_W | Register targeted by the write |
| rf_data | output | DATA_W | Write data |
| st_we | input | 1 | Status word write enable |
| st_widx | input | CTX_W | Status write index |
| st_wdata | input | STAT_W | Status write data |
| st_ridx | input | CTX_W | Read index |
| st_rdata | output | STAT_W | Registered status of context `st_ridx` |
| st_rrestart | output | ADDR_W | Registered restart address of context `st_ridx` |

## Verification
Two functions can meet on one edge: an ordinary status write and a fork commit. The bench provokes this by raising `st_we` in the same cycle as `req_valid`. In one case the write targets the context the fork will pick. In the other it targets an unqualified context and turns it into a qualifying one. In the first case the bench reads back the fork result, not the written word. In the second it reads back the written word, and the fork must still land on the context that qualified before the edge. Those pass/fail rules come from R11.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  localparam int PE_W    = 2;
  localparam int ASID_W  = 8;
  localparam int MODE_W  = 2;
  localparam int RUN_W   = 2;
  localparam int CAUSE_W = 3;

  // Status word, MSB first: pe[18:17] asid[16:9] mode[8:7] run[6:5]
  // dirty[4] dslot[3] halt[2] active[1] alloc[0]
  typedef struct packed {
    logic [PE_W-1:0]   pe;
    logic [ASID_W-1:0] asid;
    logic [MODE_W-1:0] mode;
    logic [RUN_W-1:0]  run;
    logic              dirty;
    logic              dslot;
    logic              halt;
    logic              active;
    logic              alloc;
  } ctx_stat_t;

  localparam int STAT_W = $bits(ctx_stat_t);

  localparam logic [CAUSE_W-1:0] CAUSE_NO_CTX = CAUSE_W'(1);
  localparam logic [RUN_W-1:0]   RUN_GO       = '0;

endpackage

// File: rtl/tcf_ctx_store.sv
module tcf_ctx_store
  import tcf_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [CTX_W-1:0]  sw_widx,
  input  ctx_stat_t         sw_wdata,
  input  logic              fk_we,
  input  logic [CTX_W-1:0]  fk_idx,
  input  ctx_stat_t         fk_stat,
  input  logic [ADDR_W-1:0] fk_start,
  input  logic [CTX_W-1:0]  rd_idx,
  output ctx_stat_t         stat_all [NUM_CTX],
  output ctx_stat_t         rd_stat,
  output logic [ADDR_W-1:0] rd_restart
);

  logic [ADDR_W-1:0] restart_mem [NUM_CTX];

  // Status words live in flops: the scan needs all of them at once.
  for (genvar g = 0; g < NUM_CTX; g++) begin : g_stat
    always_ff @(posedge clk) begin
      if (rst) begin
        stat_all[g] <= '0;
      end else if (fk_we && (fk_idx == CTX_W'(g))) begin
        stat_all[g] <= fk_stat;             // fork beats a same-edge write
      end else if (sw_we && (sw_widx == CTX_W'(g))) begin
        stat_all[g] <= sw_wdata;
      end
    end
  end

  // Restart addresses: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (fk_we) begin
      restart_mem[fk_idx] <= fk_start;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_restart <= '0;
      rd_stat    <= '0;
    end else begin
      rd_restart <= restart_mem[rd_idx];
      rd_stat    <= stat_all[rd_idx];
    end
  end

endmodule

// File: rtl/tcf_scan.sv
module tcf_scan
  import tcf_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input  ctx_stat_t        stat_all [NUM_CTX],
  input  logic [CTX_W-1:0] cfg_last,
  input  logic [PE_W-1:0]  parent_pe,
  output logic             found,
  output logic [CTX_W-1:0] pick
);

  logic [NUM_CTX-1:0] qual;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_qual
    assign qual[g] = (CTX_W'(g) <= cfg_last) &&
                     (stat_all[g].pe == parent_pe) &&
                     stat_all[g].alloc &&
                     !stat_all[g].halt &&
                     !stat_all[g].active;
  end

  // Lowest index wins: walk downward so the last hit is the smallest.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_CTX - 1; i >= 0; i--) begin
      if (qual[i]) begin
        found = 1'b1;
        pick  = CTX_W'(i);
      end
    end
  end

endmodule

// File: rtl/tcf_commit.sv
module tcf_commit
  import tcf_pkg::*;
#(
  parameter int CTX_W  = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RIDX_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [MODE_W-1:0]  req_mode,
  input  logic [ADDR_W-1:0]  req_start,
  input  logic [RIDX_W-1:0]  req_reg,
  input  logic [DATA_W-1:0]  req_value,
  input  logic               found,
  input  logic [CTX_W-1:0]   pick,
  input  ctx_stat_t          pick_stat,
  input  logic [ASID_W-1:0]  parent_asid,
  output logic               fk_we,
  output logic [CTX_W-1:0]   fk_idx,
  output ctx_stat_t          fk_stat,
  output logic [ADDR_W-1:0]  fk_start,
  output logic               ack,
  output logic               ack_ok,
  output logic [CTX_W-1:0]   ack_ctx,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic               rf_we,
  output logic [CTX_W-1:0]   rf_ctx,
  output logic [RIDX_W-1:0]  rf_idx,
  output logic [DATA_W-1:0]  rf_data
);

  logic accept;

  assign accept   = req_valid && !ack;
  assign fk_we    = accept && found;
  assign fk_idx   = pick;
  assign fk_start = req_start;

  always_comb begin
    fk_stat        = pick_stat;
    fk_stat.active = 1'b1;
    fk_stat.run    = RUN_GO;
    fk_stat.dslot  = 1'b0;
    fk_stat.dirty  = 1'b1;
    fk_stat.mode   = req_mode;
    fk_stat.asid   = parent_asid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack       <= 1'b0;
      ack_ok    <= 1'b0;
      ack_ctx   <= '0;
      exc_valid <= 1'b0;
      exc_cause <= '0;
      rf_we     <= 1'b0;
      rf_ctx    <= '0;
      rf_idx    <= '0;
      rf_data   <= '0;
    end else begin
      ack       <= accept;
      ack_ok    <= accept && found;
      exc_valid <= accept && !found;
      rf_we     <= accept && found;
      if (accept && found) begin
        ack_ctx <= pick;
        rf_ctx  <= pick;
        rf_idx  <= req_reg;
        rf_data <= req_value;
      end
      if (accept && !found) begin
        exc_cause <= CAUSE_NO_CTX;
      end
    end
  end

endmodule

// File: rtl/tc_fork_alloc.sv
module tc_fork_alloc
  import tcf_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int RIDX_W  = 5,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CTX_W-1:0]   cfg_last_ctx,
  input  logic               req_valid,
  input  logic [CTX_W-1:0]   req_parent,
  input  logic [MODE_W-1:0]  req_mode,
  input  logic [ADDR_W-1:0]  req_start,
  input  logic [RIDX_W-1:0]  req_reg,
  input  logic [DATA_W-1:0]  req_value,
  output logic               ack,
  output logic               ack_ok,
  output logic [CTX_W-1:0]   ack_ctx,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic               rf_we,
  output logic [CTX_W-1:0]   rf_ctx,
  output logic [RIDX_W-1:0]  rf_idx,
  output logic [DATA_W-1:0]  rf_data,
  input  logic               st_we,
  input  logic [CTX_W-1:0]   st_widx,
  input  logic [STAT_W-1:0]  st_wdata,
  input  logic [CTX_W-1:0]   st_ridx,
  output logic [STAT_W-1:0]  st_rdata,
  output logic [ADDR_W-1:0]  st_rrestart
);

  ctx_stat_t         stat_all [NUM_CTX];
  ctx_stat_t         rd_stat;
  ctx_stat_t         fk_stat;
  logic              fk_we;
  logic [CTX_W-1:0]  fk_idx;
  logic [ADDR_W-1:0] fk_start;
  logic              found;
  logic [CTX_W-1:0]  pick;

  assign st_rdata = rd_stat;

  tcf_ctx_store #(
    .NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .ADDR_W(ADDR_W)
  ) store_i (
    .clk       (clk),
    .rst       (rst),
    .sw_we     (st_we),
    .sw_widx   (st_widx),
    .sw_wdata  (ctx_stat_t'(st_wdata)),
    .fk_we     (fk_we),
    .fk_idx    (fk_idx),
    .fk_stat   (fk_stat),
    .fk_start  (fk_start),
    .rd_idx    (st_ridx),
    .stat_all  (stat_all),
    .rd_stat   (rd_stat),
    .rd_restart(st_rrestart)
  );

  tcf_scan #(
    .NUM_CTX(NUM_CTX), .CTX_W(CTX_W)
  ) scan_i (
    .stat_all (stat_all),
    .cfg_last (cfg_last_ctx),
    .parent_pe(stat_all[req_parent].pe),
    .found    (found),
    .pick     (pick)
  );

  tcf_commit #(
    .CTX_W(CTX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RIDX_W(RIDX_W)
  ) commit_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .req_start  (req_start),
    .req_reg    (req_reg),
    .req_value  (req_value),
    .found      (found),
    .pick       (pick),
    .pick_stat  (stat_all[pick]),
    .parent_asid(stat_all[req_parent].asid),
    .fk_we      (fk_we),
    .fk_idx     (fk_idx),
    .fk_stat    (fk_stat),
    .fk_start   (fk_start),
    .ack        (ack),
    .ack_ok     (ack_ok),
    .ack_ctx    (ack_ctx),
    .exc_valid  (exc_valid),
    .exc_cause  (exc_cause),
    .rf_we      (rf_we),
    .rf_ctx     (rf_ctx),
    .rf_idx     (rf_idx),
    .rf_data    (rf_data)
  );

endmodule

// File: rtl/tcf_chk.sv
module tcf_chk
  import tcf_pkg::*;
#(
  parameter int CTX_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [CTX_W-1:0]   cfg_last_ctx,
  input logic               req_valid,
  input logic               ack,
  input logic               ack_ok,
  input logic [CTX_W-1:0]   ack_ctx,
  input logic               exc_valid,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic               rf_we,
  input logic [CTX_W-1:0]   rf_ctx
);

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R9
  AST_ACK_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(req_valid)); // R9
  AST_EXC_NO_OK: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (ack && !ack_ok && exc_cause == CAUSE_NO_CTX)); // R8
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
    (exc_cause != '0) |=> (exc_cause == $past(exc_cause))); // R8
  AST_RF_ON_OK: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (ack && ack_ok && rf_ctx == ack_ctx)); // R7
  AST_OK_WRITES_RF: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_ok) |-> rf_we); // R7
  AST_PICK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ack_ok |-> (ack_ctx <= cfg_last_ctx)); // R1

endmodule

bind tc_fork_alloc tcf_chk #(.CTX_W(CTX_W)) chk_i (.*);

// File: tb/tc_fork_alloc_tb_top.sv
`timescale 1ns/1ps
module tc_fork_alloc_tb_top;
  import tcf_pkg::*;

  localparam int NUM_CTX = 4;
  localparam int CTX_W   = 2;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int RIDX_W  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CTX_W-1:0] cfg_last_ctx = '0;
  logic req_valid = 1'b0;
  logic [CTX_W-1:0] req_parent = '0;
  logic [MODE_W-1:0] req_mode = '0;
  logic [ADDR_W-1:0] req_start = '0;
  logic [RIDX_W-1:0] req_reg = '0;
  logic [DATA_W-1:0] req_value = '0;
  logic ack, ack_ok, exc_valid, rf_we;
  logic [CTX_W-1:0] ack_ctx, rf_ctx;
  logic [CAUSE_W-1:0] exc_cause;
  logic [RIDX_W-1:0] rf_idx;
  logic [DATA_W-1:0] rf_data;
  logic st_we = 1'b0;
  logic [CTX_W-1:0] st_widx = '0;
  logic [STAT_W-1:0] st_wdata = '0;
  logic [CTX_W-1:0] st_ridx = '0;
  logic [STAT_W-1:0] st_rdata;
  logic [ADDR_W-1:0] st_rrestart;

  always #4 clk = ~clk;

  tc_fork_alloc #(
    .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RIDX_W(RIDX_W)
  ) dut_i (.*);

  int checks = 0;
  int errors = 0;
  ctx_stat_t m_st [NUM_CTX];
  logic [ADDR_W-1:0] m_rs [NUM_CTX];
  logic [CAUSE_W-1:0] m_cause = '0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] step(logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic ctx_stat_t gen(logic [31:0] r);
    ctx_stat_t s;
    s.pe = {1'b0, r[0]};
    s.alloc = r[1] | r[2];
    s.halt = r[3] & r[4];
    s.active = r[5] & r[6];
    s.dslot = r[7];
    s.dirty = r[8];
    s.run = r[10:9];
    s.mode = r[12:11];
    s.asid = r[20:13];
    return s;
  endfunction

  task automatic wr_stat(int idx, ctx_stat_t s);
    @(negedge clk);
    st_we = 1'b1; st_widx = CTX_W'(idx); st_wdata = s;
    @(negedge clk);
    st_we = 1'b0;
    m_st[idx] = s;
  endtask

  task automatic verify_all(string tag, int restart_idx);
    for (int i = 0; i < NUM_CTX; i++) begin
      @(negedge clk); st_ridx = CTX_W'(i);
      @(negedge clk);
      chk(tag, $sformatf("status ctx%0d", i), 64'(st_rdata), 64'(m_st[i]));
      if (i == restart_idx) chk("R6", "restart address", 64'(st_rrestart), 64'(m_rs[i]));
    end
  endtask

  // Fork with optional same-edge status write and optional held request.
  task automatic do_fork(int parent, int cfg, logic [MODE_W-1:0] mode,
                         logic [ADDR_W-1:0] start, logic [RIDX_W-1:0] rg,
                         logic [DATA_W-1:0] val, bit coll, int cidx,
                         ctx_stat_t cword, bit hold, int exp_pick);
    bit found = 0;
    int pk = 0;
    ctx_stat_t child;
    for (int i = 0; i <= cfg && i < NUM_CTX; i++) begin
      if (!found && m_st[i].pe == m_st[parent].pe && m_st[i].alloc &&
          !m_st[i].halt && !m_st[i].active) begin
        found = 1; pk = i;
      end
    end
    if (exp_pick >= 0) chk("R2", "planned pick", 64'(pk), 64'(exp_pick));
    child = m_st[pk];
    child.active = 1'b1; child.run = '0; child.dslot = 1'b0; child.dirty = 1'b1;
    child.mode = mode; child.asid = m_st[parent].asid;
    @(negedge clk);
    cfg_last_ctx = CTX_W'(cfg); req_parent = CTX_W'(parent); req_mode = mode;
    req_start = start; req_reg = rg; req_value = val; req_valid = 1'b1;
    if (coll) begin st_we = 1'b1; st_widx = CTX_W'(cidx); st_wdata = cword; end
    @(negedge clk);
    st_we = 1'b0;
    if (!hold) req_valid = 1'b0;
    chk("R9", "ack", 64'(ack), 64'(1));
    chk("R3", "ack_ok", 64'(ack_ok), 64'(found));
    chk("R7", "rf_we", 64'(rf_we), 64'(found));
    chk("R8", "exc_valid", 64'(exc_valid), 64'(!found));
    if (!found) m_cause = CAUSE_NO_CTX;
    chk("R8", "exc_cause", 64'(exc_cause), 64'(m_cause));
    if (found) begin
      chk("R2", "ack_ctx", 64'(ack_ctx), 64'(pk));
      chk("R7", "rf_ctx", 64'(rf_ctx), 64'(pk));
      chk("R7", "rf_idx", 64'(rf_idx), 64'(rg));
      chk("R7", "rf_data", 64'(rf_data), 64'(val));
    end
    if (coll && !(found && cidx == pk)) m_st[cidx] = cword;
    if (found) begin m_st[pk] = child; m_rs[pk] = start; end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "ack falls", 64'(ack), 64'(0));
    chk("R9", "no write after ack", 64'(rf_we), 64'(0));
    chk("R8", "exc pulse ends", 64'(exc_valid), 64'(0));
    verify_all(found ? "R4" : "R8", found ? pk : -1);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    ctx_stat_t s, q, w;
    for (int i = 0; i < NUM_CTX; i++) begin m_st[i] = '0; m_rs[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk("R12", "ack", 64'(ack), 64'(0));
    chk("R12", "ack_ok", 64'(ack_ok), 64'(0));
    chk("R12", "exc_valid", 64'(exc_valid), 64'(0));
    chk("R12", "exc_cause", 64'(exc_cause), 64'(0));
    chk("R12", "rf_we", 64'(rf_we), 64'(0));
    verify_all("R12", -1);

    // R10: write then read back
    s = gen(32'h00ABCDEF);
    wr_stat(2, s);
    verify_all("R10", -1);

    // R2: all qualify, lowest wins
    for (int i = 0; i < NUM_CTX; i++) begin
      s = '0; s.alloc = 1'b1; s.pe = 2'd1; s.asid = 8'(8'h10 + i); wr_stat(i, s);
    end
    do_fork(3, 3, 2'd2, 16'hA000, 5'd7, 16'h5555, 0, 0, '0, 0, 0);
    // R1: only ctx3 qualifies; cfg 2 excludes it, cfg 3 includes it
    for (int i = 0; i < 3; i++) begin
      s = '0; s.alloc = 1'b1; s.pe = 2'd1; s.active = 1'b1; wr_stat(i, s);
    end
    s = '0; s.alloc = 1'b1; s.pe = 2'd1; wr_stat(3, s);
    do_fork(0, 2, 2'd1, 16'hB000, 5'd3, 16'h1111, 0, 0, '0, 0, -1);
    do_fork(0, 3, 2'd1, 16'hB004, 5'd3, 16'h2222, 0, 0, '0, 0, 3);

    // R11 case a: write hits the chosen context on the fork edge
    s = '0; s.pe = 2'd1; s.active = 1'b1; s.alloc = 1'b1; s.asid = 8'h77; wr_stat(0, s);
    s = '0; s.pe = 2'd1; s.alloc = 1'b1; s.dslot = 1'b1; wr_stat(1, s);
    s = '0; s.pe = 2'd2; s.alloc = 1'b1; wr_stat(2, s);
    s = '0; s.pe = 2'd1; s.alloc = 1'b1; s.halt = 1'b1; wr_stat(3, s);
    w = '0; w.pe = 2'd1; w.halt = 1'b1; w.asid = 8'hEE;
    do_fork(0, 3, 2'd3, 16'hC000, 5'd9, 16'h3333, 1, 1, w, 0, 1);
    // R11 case b: write makes ctx0 qualify on the fork edge; ctx2 still chosen
    s = '0; s.pe = 2'd1; s.active = 1'b1; s.alloc = 1'b1; wr_stat(0, s);
    s = '0; s.pe = 2'd1; s.alloc = 1'b1; wr_stat(2, s);
    s = '0; s.pe = 2'd1; s.active = 1'b1; s.alloc = 1'b1; s.asid = 8'h42; wr_stat(3, s);
    q = '0; q.pe = 2'd1; q.alloc = 1'b1; q.asid = 8'h99;
    do_fork(3, 3, 2'd0, 16'hD000, 5'd1, 16'h4444, 1, 0, q, 0, 2);
    // R9: request held through the ack cycle is not taken twice
    s = '0; s.pe = 2'd0; s.alloc = 1'b1; wr_stat(1, s);
    do_fork(0, 3, 2'd2, 16'hE000, 5'd2, 16'h6666, 0, 0, '0, 1, 0);

    // R3 R4 R5 R8: sweep over generated contexts, all parents and ranges
    for (int t = 0; t < 192; t++) begin
      for (int i = 0; i < NUM_CTX; i++) begin
        seed = step(seed);
        wr_stat(i, gen(seed));
      end
      seed = step(seed);
      do_fork((t / 4) % 4, t % 4, seed[1:0], seed[17:2], seed[22:18],
              seed[31:16], 0, 0, '0, 0, -1);
    end
    summary();
  end

endmodule